// File: doc/BRIEF.md
# Packed SIMD Instruction Byte Decoder

This block sits in front of the execution unit for a 64-bit packed-integer SIMD extension. It takes the instruction stream one byte at a time over a valid/ready input. For each instruction it finds the two-byte escape code and reads the opcode, the ModR/M byte and, for the shift-by-count group, a trailing 8-bit count. From these it produces one decoded record: operation class, element size, destination and source register numbers, a memory-source flag, the count byte, and the raw mode and r/m bits. An external address unit uses those raw bits to finish memory operands.

The record leaves on a valid/ready output. Back-pressure is strict: while a record is valid and the consumer is not ready, the record and its valid stay fixed, and the input ready is held low so that no byte is taken. When the output register is empty or being emptied in the same cycle, the input is ready.

An opcode the decoder does not know raises a one-cycle illegal flag, and parsing restarts at the escape search. A shift-by-count instruction with the wrong ModR/M form is handled the same way. Displacement and SIB bytes, address arithmetic and execution are outside this block. A memory form therefore completes at its ModR/M byte.

Top module: `simd_byte_decoder`

## Requirements
- R1: After reset, out_valid and illegal are 0, in_ready is 1, and the parser is looking for the escape byte 0x0F.
- R2: While the parser is looking for the escape byte, every accepted byte other than 0x0F is dropped. This includes prefix bytes 0x40 to 0x4F, and such a prefix changes no field of the record that follows.
- R3: The sequence 0x0F 0x77 yields a record of class 0 with granularity 3 and with dst, src, mem, imm, mod and rm all 0. No ModR/M byte is read for it.
- R4: Class codes are listed here, with fixed opcodes taking priority over patterns. 0x6E=19, 0x7E=20, 0x6F=21, 0x7F=22, 0xDB=13, 0xDF=14, 0xEB=15, 0xEF=16. Patterns with gg as the low two bits: 1111_11gg=1, 1110_11gg=2, 1101_11gg=3, 1111_10gg=4, 1110_10gg=5, 1101_10gg=6, 1111_00gg=7, 1110_00gg=8, 1101_00gg=9, 0111_01gg=17, 0110_01gg with gg other than 11 gives 18.
- R5: For pattern classes (including the shift-by-count group), granularity equals opcode bits 1:0, with 00 byte, 01 word, 10 doubleword and 11 quadword. For the fixed opcodes it is 11.
- R6: For non-shift-count forms, dst is ModR/M bits 5:3 and src is bits 2:0. mod carries bits 7:6 and rm carries bits 2:0. mem is 1 exactly when mod is not 11. imm is 0.
- R7: The opcodes 0111_00gg need a ModR/M byte with mod 11 and reg 110, 100 or 010, which give class 10, 11 or 12 respectively. The next byte is taken as imm. dst and src both equal ModR/M bits 2:0, and mem is 0.
- R8: out_valid rises in the cycle after the last byte of an instruction is accepted. While out_valid is 1 and out_ready is 0, the record stays stable and in_ready is 0.
- R9: An opcode that is not listed in R3/R4/R7 makes illegal 1 for exactly one cycle, in the cycle after the opcode is accepted. No record is produced, and the next byte is searched for escape.
- R10: A shift-by-count instruction whose ModR/M byte breaks R7 makes illegal pulse in the cycle after the ModR/M byte. No immediate byte is read, and no record is produced.
- R11: Memory-source forms complete at the ModR/M byte. The following byte starts a new escape search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_cls | output | 5 | Operation class code (R3, R4, R7) |
| out_gran | output | 2 | Element granularity |
| out_dst | output | 3 | Destination register number |
| out_src | output | 3 | Source register number |
| out_mem | output | 1 | Source is a memory operand |
| out_imm | output | 8 | Count byte of shift-by-count forms, else 0 |
| out_mod | output | 2 | Raw ModR/M mode bits |
| out_rm | output | 3 | Raw ModR/M r/m bits |
| illegal | output | 1 | One-cycle pulse for an undecodable instruction |

## Verification
Every result is due exactly one clock after the edge that accepted the byte that settles it. That byte is the opcode for the clear instruction and for illegal opcodes, the ModR/M byte for register and memory forms and for a bad shift-by-count form, and the count byte otherwise. The bench model updates at each rising edge from the same accepted byte and compares out_valid, illegal, in_ready and every record field at the following falling edge. A settled result is therefore always checked in the cycle it is due. The stall phase holds out_ready low for several cycles and checks on each of them that the record stays frozen and that in_ready stays low.

// File: rtl/simd_dec_pkg.sv
package simd_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 3;
  localparam int GRAN_W = 2;
  localparam int MOD_W  = 2;
  localparam int CLS_W  = 5;

  localparam logic [BYTE_W-1:0] ESC_BYTE  = 8'h0F;
  localparam logic [GRAN_W-1:0] GRAN_FULL = 2'b11;
  localparam logic [MOD_W-1:0]  MOD_REG   = 2'b11;

  typedef enum logic [CLS_W-1:0] {
    C_CLEAR  = 5'd0,
    C_ADD    = 5'd1,  C_ADDS  = 5'd2,  C_ADDUS = 5'd3,
    C_SUB    = 5'd4,  C_SUBS  = 5'd5,  C_SUBUS = 5'd6,
    C_SLL    = 5'd7,  C_SRA   = 5'd8,  C_SRL   = 5'd9,
    C_SLLI   = 5'd10, C_SRAI  = 5'd11, C_SRLI  = 5'd12,
    C_AND    = 5'd13, C_ANDN  = 5'd14, C_OR    = 5'd15, C_XOR = 5'd16,
    C_CMPEQ  = 5'd17, C_CMPGT = 5'd18,
    C_LDD    = 5'd19, C_STD   = 5'd20, C_LDQ   = 5'd21, C_STQ = 5'd22
  } op_cls_e;

  typedef struct packed {
    op_cls_e           cls;
    logic [GRAN_W-1:0] gran;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src;
    logic              mem;
    logic [BYTE_W-1:0] imm;
    logic [MOD_W-1:0]  mode;
    logic [REG_W-1:0]  rm;
  } dec_rec_t;

  typedef enum logic [1:0] {
    PS_ESC, PS_OPC, PS_MODRM, PS_IMM
  } parse_st_e;
endpackage

// File: rtl/simd_opc_classify.sv
module simd_opc_classify
  import simd_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] opc,
  output op_cls_e           cls,
  output logic              known,
  output logic              has_gran,
  output logic              needs_modrm,
  output logic              shcnt_grp
);
  always_comb begin
    cls         = C_CLEAR;
    known       = 1'b1;
    has_gran    = 1'b0;
    needs_modrm = 1'b1;
    shcnt_grp   = 1'b0;
    case (opc)
      8'h77: needs_modrm = 1'b0;
      8'h6E: cls = C_LDD;
      8'h7E: cls = C_STD;
      8'h6F: cls = C_LDQ;
      8'h7F: cls = C_STQ;
      8'hDB: cls = C_AND;
      8'hDF: cls = C_ANDN;
      8'hEB: cls = C_OR;
      8'hEF: cls = C_XOR;
      default: begin
        has_gran = 1'b1;
        casez (opc)
          8'b1111_11??: cls = C_ADD;
          8'b1110_11??: cls = C_ADDS;
          8'b1101_11??: cls = C_ADDUS;
          8'b1111_10??: cls = C_SUB;
          8'b1110_10??: cls = C_SUBS;
          8'b1101_10??: cls = C_SUBUS;
          8'b1111_00??: cls = C_SLL;
          8'b1110_00??: cls = C_SRA;
          8'b1101_00??: cls = C_SRL;
          8'b0111_00??: begin
            cls       = C_SLLI;
            shcnt_grp = 1'b1;
          end
          8'b0111_01??: cls = C_CMPEQ;
          8'b0110_01??: begin
            cls   = C_CMPGT;
            known = (opc[1:0] != 2'b11);
          end
          default: begin
            known    = 1'b0;
            has_gran = 1'b0;
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/simd_shcnt_resolve.sv
module simd_shcnt_resolve
  import simd_dec_pkg::*;
(
  input  logic [MOD_W-1:0] mode,
  input  logic [REG_W-1:0] sel,
  output op_cls_e          cls,
  output logic             ok
);
  always_comb begin
    cls = C_SLLI;
    ok  = (mode == MOD_REG);
    case (sel)
      3'b110:  cls = C_SLLI;
      3'b100:  cls = C_SRAI;
      3'b010:  cls = C_SRLI;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/simd_dec_parse.sv
module simd_dec_parse
  import simd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  op_cls_e           opc_cls,
  input  logic              opc_known,
  input  logic              opc_has_gran,
  input  logic              opc_needs_modrm,
  input  logic              opc_shcnt,
  input  op_cls_e           sh_cls,
  input  logic              sh_ok,
  output logic              out_valid,
  input  logic              out_ready,
  output dec_rec_t          out_rec,
  output logic              illegal
);
  parse_st_e         st;
  op_cls_e           cls_q;
  logic [GRAN_W-1:0] gran_q;
  logic              shcnt_q;
  logic [REG_W-1:0]  rm_q;
  logic              accept;

  logic [MOD_W-1:0]  b_mode;
  logic [REG_W-1:0]  b_reg;
  logic [REG_W-1:0]  b_rm;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign b_mode   = in_byte[7:6];
  assign b_reg    = in_byte[5:3];
  assign b_rm     = in_byte[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= PS_ESC;
      cls_q     <= C_CLEAR;
      gran_q    <= '0;
      shcnt_q   <= 1'b0;
      rm_q      <= '0;
      out_valid <= 1'b0;
      out_rec   <= '0;
      illegal   <= 1'b0;
    end else begin
      illegal <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (accept) begin
        case (st)
          PS_ESC: begin
            if (in_byte == ESC_BYTE) st <= PS_OPC;
          end
          PS_OPC: begin
            if (!opc_known) begin
              illegal <= 1'b1;
              st      <= PS_ESC;
            end else if (!opc_needs_modrm) begin
              out_rec      <= '0;
              out_rec.cls  <= C_CLEAR;
              out_rec.gran <= GRAN_FULL;
              out_valid    <= 1'b1;
              st           <= PS_ESC;
            end else begin
              cls_q   <= opc_cls;
              gran_q  <= opc_has_gran ? in_byte[1:0] : GRAN_FULL;
              shcnt_q <= opc_shcnt;
              st      <= PS_MODRM;
            end
          end
          PS_MODRM: begin
            if (shcnt_q) begin
              if (!sh_ok) begin
                illegal <= 1'b1;
                st      <= PS_ESC;
              end else begin
                cls_q <= sh_cls;
                rm_q  <= b_rm;
                st    <= PS_IMM;
              end
            end else begin
              out_rec.cls  <= cls_q;
              out_rec.gran <= gran_q;
              out_rec.dst  <= b_reg;
              out_rec.src  <= b_rm;
              out_rec.mem  <= (b_mode != MOD_REG);
              out_rec.imm  <= '0;
              out_rec.mode <= b_mode;
              out_rec.rm   <= b_rm;
              out_valid    <= 1'b1;
              st           <= PS_ESC;
            end
          end
          PS_IMM: begin
            out_rec.cls  <= cls_q;
            out_rec.gran <= gran_q;
            out_rec.dst  <= rm_q;
            out_rec.src  <= rm_q;
            out_rec.mem  <= 1'b0;
            out_rec.imm  <= in_byte;
            out_rec.mode <= MOD_REG;
            out_rec.rm   <= rm_q;
            out_valid    <= 1'b1;
            st           <= PS_ESC;
          end
          default: st <= PS_ESC;
        endcase
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));

  // R9
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);

  // R9
  illegal_no_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !$rose(out_valid));

  // R7
  shcnt_regform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_rec.cls inside {C_SLLI, C_SRAI, C_SRLI}))
      |-> (out_rec.mode == MOD_REG && !out_rec.mem && out_rec.dst == out_rec.rm));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rec.cls == C_CLEAR)
      |-> (out_rec.imm == '0 && out_rec.mode == '0 && out_rec.gran == GRAN_FULL));
endmodule

// File: rtl/simd_byte_decoder.sv
module simd_byte_decoder
  import simd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CLS_W-1:0]  out_cls,
  output logic [GRAN_W-1:0] out_gran,
  output logic [REG_W-1:0]  out_dst,
  output logic [REG_W-1:0]  out_src,
  output logic              out_mem,
  output logic [BYTE_W-1:0] out_imm,
  output logic [MOD_W-1:0]  out_mod,
  output logic [REG_W-1:0]  out_rm,
  output logic              illegal
);
  op_cls_e  opc_cls;
  logic     opc_known;
  logic     opc_has_gran;
  logic     opc_needs_modrm;
  logic     opc_shcnt;
  op_cls_e  sh_cls;
  logic     sh_ok;
  dec_rec_t rec;

  simd_opc_classify u_classify (
    .opc         (in_byte),
    .cls         (opc_cls),
    .known       (opc_known),
    .has_gran    (opc_has_gran),
    .needs_modrm (opc_needs_modrm),
    .shcnt_grp   (opc_shcnt)
  );

  simd_shcnt_resolve u_shcnt (
    .mode (in_byte[7:6]),
    .sel  (in_byte[5:3]),
    .cls  (sh_cls),
    .ok   (sh_ok)
  );

  simd_dec_parse u_parse (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_byte         (in_byte),
    .in_ready        (in_ready),
    .opc_cls         (opc_cls),
    .opc_known       (opc_known),
    .opc_has_gran    (opc_has_gran),
    .opc_needs_modrm (opc_needs_modrm),
    .opc_shcnt       (opc_shcnt),
    .sh_cls          (sh_cls),
    .sh_ok           (sh_ok),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_rec         (rec),
    .illegal         (illegal)
  );

  assign out_cls  = rec.cls;
  assign out_gran = rec.gran;
  assign out_dst  = rec.dst;
  assign out_src  = rec.src;
  assign out_mem  = rec.mem;
  assign out_imm  = rec.imm;
  assign out_mod  = rec.mode;
  assign out_rm   = rec.rm;
endmodule

// File: tb/simd_byte_decoder_bench.sv
module simd_byte_decoder_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, in_valid, out_ready;
  logic [7:0] in_byte;
  logic       in_ready, out_valid, out_mem, illegal;
  logic [4:0] out_cls;
  logic [1:0] out_gran, out_mod;
  logic [2:0] out_dst, out_src, out_rm;
  logic [7:0] out_imm;

  simd_byte_decoder u_simd_byte_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_cls(out_cls), .out_gran(out_gran), .out_dst(out_dst),
    .out_src(out_src), .out_mem(out_mem), .out_imm(out_imm),
    .out_mod(out_mod), .out_rm(out_rm), .illegal(illegal)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  logic [7:0] q[$];
  bit         m_ov = 0, m_ill = 0;
  int         m_cls, m_gran, m_dst, m_src, m_mem, m_imm, m_mod, m_rm;
  int         m_recs = 0, m_ills = 0, seen_recs = 0, seen_ills = 0;

  function automatic int ref_cls(input logic [7:0] op);
    if (op == 8'h77) return 0;
    if (op == 8'h6E) return 19;
    if (op == 8'h7E) return 20;
    if (op == 8'h6F) return 21;
    if (op == 8'h7F) return 22;
    if (op == 8'hDB) return 13;
    if (op == 8'hDF) return 14;
    if (op == 8'hEB) return 15;
    if (op == 8'hEF) return 16;
    case (op >> 2)
      8'h3F: return 1;  8'h3B: return 2;  8'h37: return 3;
      8'h3E: return 4;  8'h3A: return 5;  8'h36: return 6;
      8'h3C: return 7;  8'h38: return 8;  8'h34: return 9;
      8'h1C: return 99;
      8'h1D: return 17;
      8'h19: return (op[1:0] == 2'b11) ? -1 : 18;
      default: return -1;
    endcase
  endfunction

  function automatic void put_rec(int c, int g, int d, int s, int me, int im, int mo, int r);
    m_cls = c; m_gran = g; m_dst = d; m_src = s; m_mem = me;
    m_imm = im; m_mod = mo; m_rm = r; m_ov = 1; m_recs++;
  endfunction

  always @(posedge clk) begin
    bit rdy;
    int c, md, rg;
    if (!rst_n) begin
      q.delete(); m_ov = 0; m_ill = 0;
    end else begin
      rdy = !m_ov || out_ready;
      if (m_ov && out_ready) m_ov = 0;
      m_ill = 0;
      if (in_valid && rdy) begin
        q.push_back(in_byte);
        if (q.size() == 1) begin
          if (q[0] != 8'h0F) q.delete();
        end else if (q.size() == 2) begin
          c = ref_cls(q[1]);
          if (c < 0) begin m_ill = 1; m_ills++; q.delete(); end
          else if (c == 0) begin put_rec(0, 3, 0, 0, 0, 0, 0, 0); q.delete(); end
        end else if (q.size() == 3) begin
          c  = ref_cls(q[1]);
          md = int'(q[2][7:6]);
          rg = int'(q[2][5:3]);
          if (c == 99) begin
            if (md != 3 || !(rg == 6 || rg == 4 || rg == 2)) begin
              m_ill = 1; m_ills++; q.delete();
            end
          end else begin
            put_rec(c, (c >= 13 && c <= 16) || c >= 19 ? 3 : int'(q[1][1:0]),
                    rg, int'(q[2][2:0]), md != 3, 0, md, int'(q[2][2:0]));
            q.delete();
          end
        end else begin
          rg = int'(q[2][5:3]);
          c  = (rg == 6) ? 10 : (rg == 4) ? 11 : 12;
          put_rec(c, int'(q[1][1:0]), int'(q[2][2:0]), int'(q[2][2:0]),
                  0, int'(q[3]), 3, int'(q[2][2:0]));
          q.delete();
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, half a cycle after every edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == m_ov, "out_valid", out_valid, m_ov);
      chk(illegal == m_ill, "illegal", illegal, m_ill);
      chk(in_ready == (!m_ov || out_ready), "in_ready", in_ready, !m_ov || out_ready);
      if (out_valid && m_ov) begin
        chk(out_cls == m_cls, "cls", out_cls, m_cls);
        chk(out_gran == m_gran, "gran", out_gran, m_gran);
        chk(out_dst == m_dst, "dst", out_dst, m_dst);
        chk(out_src == m_src, "src", out_src, m_src);
        chk(out_mem == m_mem, "mem", out_mem, m_mem);
        chk(out_imm == m_imm, "imm", out_imm, m_imm);
        chk(out_mod == m_mod, "mod", out_mod, m_mod);
        chk(out_rm == m_rm, "rm", out_rm, m_rm);
      end
      if (out_valid && out_ready) seen_recs++;
      if (illegal) seen_ills++;
    end
  end

  task automatic summary();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL %s watchdog expired", cur_req);
    summary();
  end

  // called at posedge+5; returns at posedge+5 after acceptance
  task automatic send(input logic [7:0] b);
    bit r;
    in_valid = 1; in_byte = b;
    forever begin
      @(negedge clk); r = in_ready;
      @(posedge clk);
      if (r) break;
    end
    #5 in_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic phase_end(input int rec_before, input int ill_before);
    idle(3);
    chk(seen_recs - rec_before == m_recs - rec_before, "record count",
        seen_recs - rec_before, m_recs - rec_before);
    chk(seen_ills - ill_before == m_ills - ill_before, "illegal count",
        seen_ills - ill_before, m_ills - ill_before);
  endtask

  initial begin
    int rb, ib;
    logic [7:0] opl[19];
    rst_n = 0; in_valid = 0; in_byte = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    chk(out_valid == 0, "reset out_valid", out_valid, 0);
    chk(illegal == 0, "reset illegal", illegal, 0);
    chk(in_ready == 1, "reset in_ready", in_ready, 1);
    @(posedge clk); #5;

    // R2: stray and prefix bytes before escape
    cur_req = "R2"; rb = m_recs; ib = m_ills;
    send(8'h45); send(8'h12); send(8'h4F); send(8'h0F); send(8'hFD); send(8'hC1);
    send(8'h0F); send(8'hFD); send(8'hC1);
    phase_end(rb, ib);
    chk(m_recs - rb == 2, "two records expected", m_recs - rb, 2);

    // R3: clear instruction, then an add back to back
    cur_req = "R3"; rb = m_recs; ib = m_ills;
    send(8'h0F); send(8'h77); send(8'h0F); send(8'hFC); send(8'hC8);
    phase_end(rb, ib);

    // R4: class table
    cur_req = "R4"; rb = m_recs; ib = m_ills;
    opl = '{8'hFC, 8'hED, 8'hDE, 8'hF9, 8'hE8, 8'hD9, 8'hF2, 8'hE1, 8'hD3,
            8'hDB, 8'hDF, 8'hEB, 8'hEF, 8'h74, 8'h65, 8'h6E, 8'h7E, 8'h6F, 8'h7F};
    foreach (opl[i]) begin send(8'h0F); send(opl[i]); send(8'hD1); end
    phase_end(rb, ib);

    // R5: every granularity on several patterns
    cur_req = "R5"; rb = m_recs; ib = m_ills;
    for (int g = 0; g < 4; g++) begin
      send(8'h0F); send(8'hFC | 8'(g)); send(8'hC0);
      send(8'h0F); send(8'hD0 | 8'(g)); send(8'hDA);
      send(8'h0F); send(8'h70 | 8'(g)); send(8'hF4); send(8'(g * 7));
    end
    phase_end(rb, ib);

    // R6: ModR/M field variants
    cur_req = "R6"; rb = m_recs; ib = m_ills;
    send(8'h0F); send(8'hEF); send(8'h00);
    send(8'h0F); send(8'hEF); send(8'h7F);
    send(8'h0F); send(8'hE9); send(8'h85);
    send(8'h0F); send(8'h6F); send(8'hC7);
    send(8'h0F); send(8'hF8); send(8'h4B);
    phase_end(rb, ib);

    // R7: shift-by-count forms
    cur_req = "R7"; rb = m_recs; ib = m_ills;
    send(8'h0F); send(8'h71); send(8'hF3); send(8'h05);
    send(8'h0F); send(8'h72); send(8'hE2); send(8'h80);
    send(8'h0F); send(8'h73); send(8'hD5); send(8'hFF);
    phase_end(rb, ib);

    // R8: output stall
    cur_req = "R8"; rb = m_recs; ib = m_ills;
    out_ready = 0;
    fork
      begin
        send(8'h0F); send(8'hFE); send(8'hD3);
        send(8'h0F); send(8'h77);
      end
      begin
        idle(8); out_ready = 1; idle(2); out_ready = 0; idle(4); out_ready = 1;
      end
    join
    phase_end(rb, ib);

    // R9: unknown opcodes
    cur_req = "R9"; rb = m_recs; ib = m_ills;
    send(8'h0F); send(8'h00);
    send(8'h0F); send(8'h67);
    send(8'h0F); send(8'h7B);
    send(8'h0F); send(8'hDD); send(8'hC9);
    phase_end(rb, ib);
    chk(m_ills - ib == 3, "three illegal pulses", m_ills - ib, 3);

    // R10: bad shift-by-count ModR/M
    cur_req = "R10"; rb = m_recs; ib = m_ills;
    send(8'h0F); send(8'h71); send(8'h35);
    send(8'h0F); send(8'hFC); send(8'hC0);
    send(8'h0F); send(8'h72); send(8'hC0);
    send(8'h0F); send(8'h77);
    phase_end(rb, ib);

    // R11: memory forms complete at ModR/M
    cur_req = "R11"; rb = m_recs; ib = m_ills;
    send(8'h0F); send(8'hFC); send(8'h05);
    send(8'h0F); send(8'h6E); send(8'h44);
    send(8'h0F); send(8'h77);
    phase_end(rb, ib);
    chk(m_recs - rb == 3, "three records expected", m_recs - rb, 3);

    summary();
  end
endmodule